// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block holds one DMA channel's programming state and drives a buffer transfer as a series of single data transfers. Software loads a requester address, a target address, a 24-bit byte count and a control word through a simple write port. Once the channel is enabled, each service request is turned into one transfer offered to a bus cycle engine over a valid/ready pair. The offer carries both addresses, the transfer width and the direction. When the engine strobes completion, the channel updates the count and both addresses.

Service is requested either by a hardware request line or by a software request bit in the control word, which is used when the requester sits in memory. The buffer ends normally when the count steps past zero to all-ones, so one more byte moves than the programmed count. An active-low end-of-process input ends it early, after the transfer in flight. Either ending raises a one-cycle done pulse, sets a sticky status bit for that kind of ending and disables the channel.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset no transfer is offered, busy, done and both status bits are low, and the count reads zero.
- R2: Register index 0 loads the requester address, 1 the target address, 2 the count (low 24 bits) and 3 the control word. Control bit 0 enables, bit 1 selects word width (else byte), bits 3:2 are the requester step mode, bits 5:4 the target step mode, bit 6 the direction (1 = target to requester) and bit 7 the software request. When enabled with a request, the channel offers a transfer carrying the current addresses, width and direction.
- R3: An enabled channel whose hardware request input is low and whose software request bit is clear offers no transfer.
- R4: Each completed transfer lowers the count by 1 for byte width and by 2 for word width, modulo 2^24.
- R5: After each completed transfer each address moves by the transfer size: up for step mode 01, down for 10, unchanged for 00 and 11, with wrap-around.
- R6: A transfer that takes the count below zero ends the buffer. A byte-wide buffer makes count+1 transfers. Done pulses for exactly one cycle, the terminal status bit sets, and the channel goes idle with no further offers.
- R7: If end-of-process is low at any point during a transfer, or while the channel waits for a request, the buffer ends after that transfer with the early-termination status bit set and a done pulse. Terminal count takes precedence when both apply.
- R8: While the channel is busy, register writes are ignored except a control write with bit 0 clear, which aborts the channel with no done pulse and no status.
- R9: A valid offer stays asserted with a stable payload until ready is seen.
- R10: Starting a new buffer clears both sticky status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register index |
| wr_data_i | input | AW | Write data |
| dreq_i | input | 1 | Hardware service request, active high |
| eop_ni | input | 1 | End-of-process, active low |
| xv_o | output | 1 | Transfer offer valid |
| xr_i | input | 1 | Bus engine accepts offer |
| x_req_addr_o | output | AW | Requester address of the offer |
| x_tgt_addr_o | output | AW | Target address of the offer |
| x_word_o | output | 1 | Offer is word wide |
| x_dir_o | output | 1 | Offer direction, 1 = target to requester |
| xd_i | input | 1 | Bus engine reports transfer finished |
| count_o | output | CW | Current byte count |
| busy_o | output | 1 | Channel enabled or transfer in progress |
| done_o | output | 1 | One-cycle buffer end pulse |
| tc_o | output | 1 | Sticky: ended on terminal count |
| eop_o | output | 1 | Sticky: ended by end-of-process |

## Verification
The bench uses the default widths, 32-bit addresses and a 24-bit count, so zero counts wrap to 24'hFFFFFF and 24'hFFFFFE. It also places addresses near 0 and near all-ones, which exercises wrap-around in both step directions. Counts are kept small, so whole buffers of both widths finish within a few dozen transfers, with random accept and finish delays. End-of-process can land on any transfer, including the terminal one, where the tie rule applies.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_KEEP = 2'b11
  } step_e;

  // bit 7 .. bit 0
  typedef struct packed {
    logic  sw_req;
    logic  dir;
    step_e tgt_step;
    step_e req_step;
    logic  word;
    logic  en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_ISSUE,
    ST_BUSY
  } state_e;

  localparam logic [1:0] SEL_REQ  = 2'd0;
  localparam logic [1:0] SEL_TGT  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
  localparam int unsigned CTRL_W  = $bits(ctrl_t);
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  step_e         mode_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] size;

  assign size = word_i ? AW'(2) : AW'(1);

  always_comb begin
    unique case (mode_i)
      STEP_INC: addr_o = addr_i + size;
      STEP_DEC: addr_o = addr_i - size;
      default:  addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_cnt_dec.sv
module dma_cnt_dec #(
  parameter int unsigned CW = 24
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          word_i,
  output logic [CW-1:0] cnt_o,
  output logic          term_o
);
  logic [CW-1:0] dec;

  assign dec    = word_i ? CW'(2) : CW'(1);
  assign cnt_o  = cnt_i - dec;
  // borrow: the count reaches or passes all-ones
  assign term_o = cnt_i < dec;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          busy_i,
  input  logic          upd_i,
  input  logic          fin_i,
  input  logic [AW-1:0] nxt_req_i,
  input  logic [AW-1:0] nxt_tgt_i,
  input  logic [CW-1:0] nxt_cnt_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] req_addr_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          start_o
);
  ctrl_t         ctrl_q;
  logic [AW-1:0] req_q, tgt_q;
  logic [CW-1:0] cnt_q;
  logic          active, accept, abort;

  assign active  = busy_i | ctrl_q.en;
  assign accept  = wr_en_i & ~active;
  assign abort   = wr_en_i & active & (wr_sel_i == SEL_CTRL) & ~wr_data_i[0];
  assign start_o = accept & (wr_sel_i == SEL_CTRL) & wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      req_q  <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept) begin
        unique case (wr_sel_i)
          SEL_REQ: req_q  <= wr_data_i;
          SEL_TGT: tgt_q  <= wr_data_i;
          SEL_CNT: cnt_q  <= wr_data_i[CW-1:0];
          default: ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        endcase
      end
      if (upd_i) begin
        req_q <= nxt_req_i;
        tgt_q <= nxt_tgt_i;
        cnt_q <= nxt_cnt_i;
      end
      if (abort || fin_i) begin
        ctrl_q.en     <= 1'b0;
        ctrl_q.sw_req <= 1'b0;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign req_addr_o = req_q;
  assign tgt_addr_o = tgt_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic req_i,
  input  logic term_i,
  input  logic eop_ni,
  input  logic xr_i,
  input  logic xd_i,
  output logic xv_o,
  output logic upd_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o,
  output logic tc_o,
  output logic eop_o
);
  state_e state_q, state_d;
  logic   eop_pend_q, eop_now;
  logic   done_d, tc_set, eop_set;

  assign eop_now = eop_pend_q | ~eop_ni;

  always_comb begin
    state_d = state_q;
    upd_o   = 1'b0;
    fin_o   = 1'b0;
    tc_set  = 1'b0;
    eop_set = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (en_i) state_d = ST_ARM;
      ST_ARM: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (eop_now) begin
          state_d = ST_IDLE;
          fin_o   = 1'b1;
          eop_set = 1'b1;
        end else if (req_i) begin
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (xr_i) state_d = ST_BUSY;
      ST_BUSY: begin
        if (xd_i) begin
          upd_o = 1'b1;
          if (!en_i) begin
            state_d = ST_IDLE;
          end else if (term_i) begin
            state_d = ST_IDLE;
            fin_o   = 1'b1;
            tc_set  = 1'b1;
          end else if (eop_now) begin
            state_d = ST_IDLE;
            fin_o   = 1'b1;
            eop_set = 1'b1;
          end else begin
            state_d = ST_ARM;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign done_d = tc_set | eop_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      eop_pend_q <= 1'b0;
      done_o     <= 1'b0;
      tc_o       <= 1'b0;
      eop_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      if (state_d == ST_IDLE)      eop_pend_q <= 1'b0;
      else if (state_q != ST_IDLE) eop_pend_q <= eop_now;
      if (start_i) begin
        tc_o  <= 1'b0;
        eop_o <= 1'b0;
      end else begin
        if (tc_set)  tc_o  <= 1'b1;
        if (eop_set) eop_o <= 1'b1;
      end
    end
  end

  assign xv_o   = state_q == ST_ISSUE;
  assign busy_o = state_q != ST_IDLE;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          dreq_i,
  input  logic          eop_ni,
  output logic          xv_o,
  input  logic          xr_i,
  output logic [AW-1:0] x_req_addr_o,
  output logic [AW-1:0] x_tgt_addr_o,
  output logic          x_word_o,
  output logic          x_dir_o,
  input  logic          xd_i,
  output logic [CW-1:0] count_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          tc_o,
  output logic          eop_o
);
  localparam int unsigned NADDR = 2;

  ctrl_t         ctrl;
  logic [AW-1:0] cur_addr [NADDR];
  logic [AW-1:0] nxt_addr [NADDR];
  step_e         mode     [NADDR];
  logic [CW-1:0] cnt, nxt_cnt;
  logic          term, upd, fin, start, fsm_busy;

  assign mode[0] = ctrl.req_step;
  assign mode[1] = ctrl.tgt_step;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .busy_i     (fsm_busy),
    .upd_i      (upd),
    .fin_i      (fin),
    .nxt_req_i  (nxt_addr[0]),
    .nxt_tgt_i  (nxt_addr[1]),
    .nxt_cnt_i  (nxt_cnt),
    .ctrl_o     (ctrl),
    .req_addr_o (cur_addr[0]),
    .tgt_addr_o (cur_addr[1]),
    .cnt_o      (cnt),
    .start_o    (start)
  );

  for (genvar g = 0; g < NADDR; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .addr_i (cur_addr[g]),
      .mode_i (mode[g]),
      .word_i (ctrl.word),
      .addr_o (nxt_addr[g])
    );
  end

  dma_cnt_dec #(.CW(CW)) u_cnt (
    .cnt_i  (cnt),
    .word_i (ctrl.word),
    .cnt_o  (nxt_cnt),
    .term_o (term)
  );

  dma_xfer_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.en),
    .start_i (start),
    .req_i   (dreq_i | ctrl.sw_req),
    .term_i  (term),
    .eop_ni  (eop_ni),
    .xr_i    (xr_i),
    .xd_i    (xd_i),
    .xv_o    (xv_o),
    .upd_o   (upd),
    .fin_o   (fin),
    .busy_o  (fsm_busy),
    .done_o  (done_o),
    .tc_o    (tc_o),
    .eop_o   (eop_o)
  );

  assign x_req_addr_o = cur_addr[0];
  assign x_tgt_addr_o = cur_addr[1];
  assign x_word_o     = ctrl.word;
  assign x_dir_o      = ctrl.dir;
  assign count_o      = cnt;
  assign busy_o       = fsm_busy | ctrl.en;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xv_o,
  input logic          xr_i,
  input logic [AW-1:0] x_req_addr_o,
  input logic [AW-1:0] x_tgt_addr_o,
  input logic          x_word_o,
  input logic          x_dir_o,
  input logic          xd_i,
  input logic [CW-1:0] count_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          tc_o,
  input logic          eop_o
);
  // R9
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xv_o && !xr_i |=> xv_o && $stable(x_req_addr_o) && $stable(x_tgt_addr_o)
                      && $stable(x_word_o) && $stable(x_dir_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !xv_o);

  // R7
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tc_o && eop_o));

  // R3
  offer_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xv_o |-> busy_o);

  // R4
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !xd_i |=> $stable(count_o));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int AW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_sel_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          dreq_i = 1'b0;
  logic          eop_ni = 1'b1;
  logic          xr_i = 1'b0;
  logic          xd_i = 1'b0;
  logic          xv_o, x_word_o, x_dir_o, busy_o, done_o, tc_o, eop_o;
  logic [AW-1:0] x_req_addr_o, x_tgt_addr_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) uut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [AW-1:0] m_step(input [AW-1:0] a, input [1:0] m, input bit w);
    case (m)
      2'b01:   return a + (w ? 2 : 1);
      2'b10:   return a - (w ? 2 : 1);
      default: return a;
    endcase
  endfunction

  task automatic wr(input [1:0] sel, input [AW-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // one buffer; eop_at = transfer index during which eop is driven, -1 for none
  task automatic run_buf(input [AW-1:0] ra, input [AW-1:0] ta, input [CW-1:0] cnt,
                         input [7:0] ctl, input int eop_at, input bit use_dreq, input bit poke);
    logic [AW-1:0] mra = ra, mta = ta;
    logic [CW-1:0] mc = cnt;
    logic [7:0] c = use_dreq ? ((ctl | 8'h01) & 8'h7F) : (ctl | 8'h81);
    bit w = c[1];
    int n = 0;
    bit term;
    wr(0, ra); wr(1, ta); wr(2, {8'h0, cnt}); dreq_i = use_dreq;
    wr(3, {24'h0, c});
    chk(!tc_o && !eop_o, "R10", {tc_o, eop_o}, 0);
    forever begin
      int t = 0;
      while (!xv_o && t < 20) begin @(negedge clk); t++; end
      chk(xv_o, "R2", xv_o, 1);
      if (!xv_o) break;
      chk(x_req_addr_o == mra && x_tgt_addr_o == mta, "R5", {x_req_addr_o, x_tgt_addr_o}, {mra, mta});
      chk(x_word_o == w && x_dir_o == c[6], "R2", {x_word_o, x_dir_o}, {w, c[6]});
      repeat ($urandom_range(0, 2)) @(negedge clk);
      chk(xv_o && x_req_addr_o == mra, "R9", x_req_addr_o, mra);
      xr_i = 1'b1;
      @(negedge clk);
      xr_i = 1'b0;
      if (n == eop_at) eop_ni = 1'b0;
      if (poke && n == 0) begin
        wr(0, 32'h5A5A_0000);
        wr(3, {24'h0, ~c | 8'h01});
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      xd_i = 1'b1;
      @(negedge clk);
      xd_i = 1'b0;
      eop_ni = 1'b1;
      term = mc < (w ? 2 : 1);
      mc = mc - (w ? 2 : 1);
      mra = m_step(mra, c[3:2], w);
      mta = m_step(mta, c[5:4], w);
      chk(count_o == mc, "R4", count_o, mc);
      if (term) begin
        chk(done_o && tc_o && !eop_o, "R6", {done_o, tc_o, eop_o}, 3'b110);
        if (!w) chk(n == int'(cnt), "R6", n, cnt);
        break;
      end else if (n == eop_at) begin
        chk(done_o && eop_o && !tc_o, "R7", {done_o, tc_o, eop_o}, 3'b101);
        break;
      end
      chk(!done_o, "R6", done_o, 0);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(!xv_o && !busy_o && !done_o, "R6", {xv_o, busy_o, done_o}, 0);
    dreq_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk(!xv_o && !busy_o && !done_o && !tc_o && !eop_o && count_o == 0, "R1",
        {xv_o, busy_o, done_o, tc_o, eop_o, count_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // byte, count 0 -> one transfer, wrap to all-ones, addresses wrap
    run_buf(32'hFFFF_FFFF, 32'h0, 24'h0, 8'b0001_0100, -1, 1'b1, 1'b0);
    chk(count_o == 24'hFF_FFFF, "R6", count_o, 24'hFF_FFFF);
    // word, count 0 -> one transfer, count wraps to FFFFFE
    run_buf(32'h0, 32'hFFFF_FFFE, 24'h0, 8'b0110_1010, -1, 1'b0, 1'b0);
    chk(count_o == 24'hFF_FFFE, "R4", count_o, 24'hFF_FFFE);
    // word, count 5 -> three transfers, hold modes 00 and 11
    run_buf(32'h100, 32'h200, 24'd5, 8'b0011_0010, -1, 1'b1, 1'b0);
    // eop early, then new start clears the sticky bit
    run_buf(32'h40, 32'h80, 24'd6, 8'b0001_0100, 2, 1'b1, 1'b0);
    chk(eop_o, "R7", eop_o, 1);
    // eop on the terminal transfer: terminal count wins
    run_buf(32'h40, 32'h80, 24'd1, 8'b0001_0100, 1, 1'b0, 1'b0);
    // writes while busy are ignored (R8)
    run_buf(32'h1000, 32'h2000, 24'd3, 8'b0100_0101, -1, 1'b1, 1'b1);

    // R3: enabled without request offers nothing; R8: abort
    wr(3, 32'h0000_0001);
    repeat (6) @(negedge clk);
    chk(!xv_o && busy_o, "R3", {xv_o, busy_o}, 2'b01);
    wr(3, 32'h0000_0000);
    @(negedge clk);
    chk(!busy_o && !done_o && !tc_o && !eop_o, "R8", {busy_o, done_o, tc_o, eop_o}, 0);

    for (int i = 0; i < 40; i++) begin
      logic [CW-1:0] cn = CW'($urandom_range(0, 7));
      int ea = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : -1;
      run_buf($urandom, $urandom, cn, 8'($urandom) & 8'h7E, ea, 1'($urandom), 1'($urandom_range(0, 4) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule